// File: doc/BRIEF.md
# Three-Level Register Access Gate

This block decides, for every register access, whether it may read and whether it may write. It keeps a password-entry register that a host fills one byte at a time. The finished entry is compared with two stored passwords, and the result is one of three privilege levels: user, level 1 or level 2. The stored passwords and the permission bits come in as static inputs from nonvolatile storage held elsewhere, and the serial bus that carries host traffic is also outside the block.

For each request, which names a table number or the auxiliary upper area, the block produces a read enable and a write enable. Level 2 may access every table. Level 1 is limited by two permission bits per table: one allows reading, the other allows reading and writing. Writes to the auxiliary upper area are allowed to level 1 only when a separate bit permits it. The entry register starts as all ones, so a stored password of all ones is granted as soon as reset ends. Password locations always read back as zero.

Top module: `pw_access_ctrl`

## Requirements
- R1: When the entry equals the level-2 password, the privilege is level 2 (code 2). When it equals only the level-1 password, the privilege is level 1 (code 1). Otherwise it is user (code 0). Level 2 wins when both passwords match.
- R2: The entry register resets to all ones. The privilege reads user while reset is held. On the first clock edge after reset is released, the privilege takes the value R1 gives for an all-ones entry.
- R3: Entry byte lane k holds entry bits [8k+7:8k]. Until all four lanes have been written at least once since reset, entry writes leave the privilege unchanged. The write that completes the fourth distinct lane updates the privilege on its own clock edge.
- R4: After the first complete entry, every further single-byte entry write re-evaluates the privilege on its own clock edge.
- R5: Write enable for table t is 1 at level 2. At level 1 it equals bit t of the read/write permission vector. At user level it is 0.
- R6: Read enable for table t is 1 at level 2. At level 1 it equals bit t of the read vector OR bit t of the read/write vector. At user level it is 0.
- R7: For the auxiliary upper area, read enable is 1 at every level. Write enable is 1 at level 2, and at level 1 only while the auxiliary level-1 write bit is set.
- R8: With no request valid, or with a table number of NUM_TABLES or above, both enables are 0.
- R9: Read data is forced to zero for a password location. Otherwise it passes the input data when read enable is 1, and is zero when read enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pw_wr_en | input | 1 | Write one byte of the password entry |
| pw_wr_lane | input | 2 | Byte lane of the entry being written |
| pw_wr_data | input | 8 | Byte value written to the entry |
| pw_l1 | input | 32 | Stored level-1 password |
| pw_l2 | input | 32 | Stored level-2 password |
| perm_rd | input | 6 | Per-table level-1 read permission |
| perm_rw | input | 6 | Per-table level-1 read/write permission |
| aux_l1_wr | input | 1 | Level 1 may write the auxiliary upper area |
| req_valid | input | 1 | Access request present |
| req_table | input | 3 | Table number of the request |
| req_aux | input | 1 | Request targets the auxiliary upper area |
| req_pw_loc | input | 1 | Request targets a password location |
| rd_data_in | input | 8 | Raw read data from storage |
| rd_en | output | 1 | Read permitted |
| wr_en | output | 1 | Write permitted |
| rd_data_out | output | 8 | Read data after masking |
| priv_level | output | 2 | Current privilege code |

## Verification
On every cycle, the assertions check four things: the privilege code is always legal, it changes only on an evaluating entry write or on the first edge after reset, user level and an idle request never yield a write, and password locations always read zero. Some behaviours can only be shown by the bench's scenarios. These are which password the privilege follows, the rule that four distinct lanes must be written before the first evaluation, and the exact grant pattern across every table, level and permission combination. The bench also covers tables beyond the last valid index.

// File: rtl/pwac_pkg.sv
package pwac_pkg;
   typedef enum logic [1:0] {
      PRIV_USER = 2'd0,
      PRIV_L1   = 2'd1,
      PRIV_L2   = 2'd2
   } priv_e;
endpackage

// File: rtl/pwac_entry.sv
// Byte-wide password entry register with lane tracking
module pwac_entry #(
   parameter int PW_BYTES = 4,
   parameter int LANE_W   = 2,
   localparam int PW_W    = PW_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [LANE_W-1:0] wr_lane,
   input  logic [7:0]        wr_data,
   output logic [PW_W-1:0]   entry_q,
   output logic [PW_W-1:0]   entry_nxt,
   output logic              eval_now
);
   logic [PW_BYTES-1:0] wr_hit;
   logic [PW_BYTES-1:0] mask_q;
   logic [PW_BYTES-1:0] mask_d;
   logic                armed_q;

   for (genvar k = 0; k < PW_BYTES; k++) begin : g_lane
      assign wr_hit[k] = wr_en && (wr_lane == LANE_W'(k));
      assign entry_nxt[k*8 +: 8] = wr_hit[k] ? wr_data : entry_q[k*8 +: 8];
   end

   assign mask_d   = mask_q | wr_hit;
   assign eval_now = (|wr_hit) && (armed_q || (&mask_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry_q <= '1;
         mask_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         entry_q <= entry_nxt;
         mask_q  <= mask_d;
         if (&mask_d) armed_q <= 1'b1;
      end
   end

   // R4: once armed, any accepted lane write must trigger evaluation
   a_r4_armed_eval: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && wr_en && (int'(wr_lane) < PW_BYTES)) |-> eval_now);
endmodule

// File: rtl/pwac_level.sv
// Password comparison and privilege register
module pwac_level
   import pwac_pkg::*;
#(
   parameter int PW_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PW_W-1:0] entry_q,
   input  logic [PW_W-1:0] entry_nxt,
   input  logic            eval_now,
   input  logic [PW_W-1:0] pw_l1,
   input  logic [PW_W-1:0] pw_l2,
   output priv_e           level_q
);
   logic  init_q;
   priv_e from_cur;
   priv_e from_nxt;

   function automatic priv_e judge(input logic [PW_W-1:0] v,
                                   input logic [PW_W-1:0] p1,
                                   input logic [PW_W-1:0] p2);
      if (v == p2)      return PRIV_L2;
      else if (v == p1) return PRIV_L1;
      else              return PRIV_USER;
   endfunction

   always_comb begin
      from_cur = judge(entry_q, pw_l1, pw_l2);
      from_nxt = judge(entry_nxt, pw_l1, pw_l2);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q  <= 1'b1;
         level_q <= PRIV_USER;
      end else begin
         init_q <= 1'b0;
         if (init_q)        level_q <= from_cur;
         else if (eval_now) level_q <= from_nxt;
      end
   end

   a_r1_level_legal: assert property (@(posedge clk) disable iff (!rst_n)
      level_q != priv_e'(2'd3));

   a_r3_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!eval_now && !init_q) |=> $stable(level_q));
endmodule

// File: rtl/pwac_perm.sv
// Per-request permission decode and read-data masking
module pwac_perm
   import pwac_pkg::*;
#(
   parameter int NUM_TABLES = 6,
   parameter int TBL_W      = 3,
   localparam int TBL_POW   = 1 << TBL_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  priv_e                 level,
   input  logic                  req_valid,
   input  logic [TBL_W-1:0]      req_table,
   input  logic                  req_aux,
   input  logic                  req_pw_loc,
   input  logic [NUM_TABLES-1:0] perm_rd,
   input  logic [NUM_TABLES-1:0] perm_rw,
   input  logic                  aux_l1_wr,
   input  logic [7:0]            rd_data_in,
   output logic                  rd_en,
   output logic                  wr_en,
   output logic [7:0]            rd_data_out
);
   logic [TBL_POW-1:0] rd_full;
   logic [TBL_POW-1:0] rw_full;
   logic               bit_rd;
   logic               bit_rw;

   if (TBL_POW == NUM_TABLES) begin : g_exact
      assign rd_full = perm_rd;
      assign rw_full = perm_rw;
   end else begin : g_pad
      assign rd_full = {{(TBL_POW-NUM_TABLES){1'b0}}, perm_rd};
      assign rw_full = {{(TBL_POW-NUM_TABLES){1'b0}}, perm_rw};
   end

   always_comb begin
      bit_rd = rd_full[req_table];
      bit_rw = rw_full[req_table];
      rd_en  = 1'b0;
      wr_en  = 1'b0;
      if (req_valid) begin
         if (req_aux) begin
            rd_en = 1'b1;
            wr_en = (level == PRIV_L2) || ((level == PRIV_L1) && aux_l1_wr);
         end else if (int'(req_table) < NUM_TABLES) begin
            rd_en = (level == PRIV_L2) || ((level == PRIV_L1) && (bit_rd || bit_rw));
            wr_en = (level == PRIV_L2) || ((level == PRIV_L1) && bit_rw);
         end
      end
      rd_data_out = (rd_en && !req_pw_loc) ? rd_data_in : 8'h00;
   end

   a_r5_user_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (level == PRIV_USER) |-> !wr_en);

   a_r7_aux_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_aux) |-> rd_en);

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!rd_en && !wr_en));

   a_r9_pw_zero: assert property (@(posedge clk) disable iff (!rst_n)
      req_pw_loc |-> (rd_data_out == 8'h00));
endmodule

// File: rtl/pw_access_ctrl.sv
// Three-level password access gate, top level
module pw_access_ctrl
   import pwac_pkg::*;
#(
   parameter int PW_BYTES   = 4,
   parameter int NUM_TABLES = 6,
   localparam int LANE_W    = $clog2(PW_BYTES),
   localparam int PW_W      = PW_BYTES * 8,
   localparam int TBL_W     = $clog2(NUM_TABLES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pw_wr_en,
   input  logic [LANE_W-1:0]     pw_wr_lane,
   input  logic [7:0]            pw_wr_data,
   input  logic [PW_W-1:0]       pw_l1,
   input  logic [PW_W-1:0]       pw_l2,
   input  logic [NUM_TABLES-1:0] perm_rd,
   input  logic [NUM_TABLES-1:0] perm_rw,
   input  logic                  aux_l1_wr,
   input  logic                  req_valid,
   input  logic [TBL_W-1:0]      req_table,
   input  logic                  req_aux,
   input  logic                  req_pw_loc,
   input  logic [7:0]            rd_data_in,
   output logic                  rd_en,
   output logic                  wr_en,
   output logic [7:0]            rd_data_out,
   output logic [1:0]            priv_level
);
   if (PW_BYTES < 2 || PW_BYTES > 16) begin : g_bad_bytes
      $error("pw_access_ctrl: PW_BYTES must lie in 2..16");
   end
   if (NUM_TABLES < 2 || NUM_TABLES > 256) begin : g_bad_tables
      $error("pw_access_ctrl: NUM_TABLES must lie in 2..256");
   end

   logic [PW_W-1:0] entry_q;
   logic [PW_W-1:0] entry_nxt;
   logic            eval_now;
   priv_e           level;

   pwac_entry #(.PW_BYTES(PW_BYTES), .LANE_W(LANE_W)) u_entry (
      .clk(clk), .rst_n(rst_n), .wr_en(pw_wr_en), .wr_lane(pw_wr_lane),
      .wr_data(pw_wr_data), .entry_q(entry_q), .entry_nxt(entry_nxt),
      .eval_now(eval_now)
   );

   pwac_level #(.PW_W(PW_W)) u_level (
      .clk(clk), .rst_n(rst_n), .entry_q(entry_q), .entry_nxt(entry_nxt),
      .eval_now(eval_now), .pw_l1(pw_l1), .pw_l2(pw_l2), .level_q(level)
   );

   pwac_perm #(.NUM_TABLES(NUM_TABLES), .TBL_W(TBL_W)) u_perm (
      .clk(clk), .rst_n(rst_n), .level(level), .req_valid(req_valid),
      .req_table(req_table), .req_aux(req_aux), .req_pw_loc(req_pw_loc),
      .perm_rd(perm_rd), .perm_rw(perm_rw), .aux_l1_wr(aux_l1_wr),
      .rd_data_in(rd_data_in), .rd_en(rd_en), .wr_en(wr_en),
      .rd_data_out(rd_data_out)
   );

   assign priv_level = level;
endmodule

// File: tb/pw_access_ctrl_bench.sv
module pw_access_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pw_wr_en = 1'b0;
   logic [1:0]  pw_wr_lane = '0;
   logic [7:0]  pw_wr_data = '0;
   logic [31:0] pw_l1 = 32'h1234_5678;
   logic [31:0] pw_l2 = 32'hCAFE_F00D;
   logic [5:0]  perm_rd = '0;
   logic [5:0]  perm_rw = '0;
   logic        aux_l1_wr = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_table = '0;
   logic        req_aux = 1'b0;
   logic        req_pw_loc = 1'b0;
   logic [7:0]  rd_data_in = 8'hA5;
   logic        rd_en, wr_en;
   logic [7:0]  rd_data_out;
   logic [1:0]  priv_level;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pw_access_ctrl u_pw_access_ctrl (
      .clk(clk), .rst_n(rst_n), .pw_wr_en(pw_wr_en), .pw_wr_lane(pw_wr_lane),
      .pw_wr_data(pw_wr_data), .pw_l1(pw_l1), .pw_l2(pw_l2),
      .perm_rd(perm_rd), .perm_rw(perm_rw), .aux_l1_wr(aux_l1_wr),
      .req_valid(req_valid), .req_table(req_table), .req_aux(req_aux),
      .req_pw_loc(req_pw_loc), .rd_data_in(rd_data_in), .rd_en(rd_en),
      .wr_en(wr_en), .rd_data_out(rd_data_out), .priv_level(priv_level)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr_byte(input logic [1:0] lane, input logic [7:0] val);
      @(negedge clk);
      pw_wr_en = 1'b1; pw_wr_lane = lane; pw_wr_data = val;
      @(negedge clk);
      pw_wr_en = 1'b0;
   endtask

   task automatic put_word(input logic [31:0] w);
      for (int k = 0; k < 4; k++) wr_byte(2'(k), w[k*8 +: 8]);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      // R2: user while reset is held
      chk("R2 level in reset", 32'(priv_level), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // expected enables from R5, R6, R8
   task automatic sweep_tables(input int lvl);
      for (int t = 0; t < 8; t++) begin
         for (int pat = 0; pat < 4; pat++) begin
            req_valid = 1'b1; req_aux = 1'b0; req_table = 3'(t);
            perm_rd = {6{pat[0]}}; perm_rw = {6{pat[1]}};
            #1;
            begin
               bit inr = (t < 6);
               bit erd = inr && (lvl == 2 || (lvl == 1 && pat != 0));
               bit ewr = inr && (lvl == 2 || (lvl == 1 && pat[1]));
               chk(inr ? "R6 table read" : "R8 out-of-range read", 32'(rd_en), 32'(erd));
               chk(inr ? "R5 table write" : "R8 out-of-range write", 32'(wr_en), 32'(ewr));
            end
         end
      end
      // single-bit pattern: only table 2 has rw, only table 4 has rd
      perm_rd = 6'b010000; perm_rw = 6'b000100;
      for (int t = 0; t < 6; t++) begin
         req_table = 3'(t); #1;
         chk("R5 per-table write bit", 32'(wr_en),
             32'(lvl == 2 || (lvl == 1 && t == 2)));
         chk("R6 per-table read bit", 32'(rd_en),
             32'(lvl == 2 || (lvl == 1 && (t == 2 || t == 4))));
      end
      for (int a = 0; a < 2; a++) begin
         req_aux = 1'b1; aux_l1_wr = a[0]; #1;
         chk("R7 aux read", 32'(rd_en), 32'd1);
         chk("R7 aux write", 32'(wr_en), 32'(lvl == 2 || (lvl == 1 && a == 1)));
      end
      req_aux = 1'b0; aux_l1_wr = 1'b0;
      req_valid = 1'b0; req_table = 3'd0; #1;
      chk("R8 idle read", 32'(rd_en), 32'd0);
      chk("R8 idle write", 32'(wr_en), 32'd0);
   endtask

   initial begin
      // R2: stored level-1 password of all ones granted right after reset
      pw_l1 = 32'hFFFF_FFFF;
      do_reset();
      chk("R2 all-ones grants level 1", 32'(priv_level), 32'd1);
      pw_l1 = 32'h1234_5678;
      do_reset();
      chk("R2 all-ones entry is user", 32'(priv_level), 32'd0);
      sweep_tables(0);

      // R3: repeated lane and partial entry do not evaluate
      for (int k = 0; k < 4; k++) wr_byte(2'd0, pw_l2[7:0]);
      chk("R3 repeated lane no change", 32'(priv_level), 32'd0);
      wr_byte(2'd1, pw_l2[15:8]);
      wr_byte(2'd2, pw_l2[23:16]);
      chk("R3 three lanes no change", 32'(priv_level), 32'd0);
      wr_byte(2'd3, pw_l2[31:24]);
      chk("R3 fourth lane evaluates", 32'(priv_level), 32'd2);
      chk("R1 level-2 match", 32'(priv_level), 32'd2);
      sweep_tables(2);

      // R4: single byte write re-evaluates
      wr_byte(2'd1, 8'h00);
      chk("R4 bad byte drops level", 32'(priv_level), 32'd0);
      wr_byte(2'd1, pw_l2[15:8]);
      chk("R4 restore byte regains", 32'(priv_level), 32'd2);

      put_word(pw_l1);
      chk("R1 level-1 match", 32'(priv_level), 32'd1);
      sweep_tables(1);

      // R1 priority when both stored passwords equal
      pw_l2 = pw_l1;
      wr_byte(2'd0, pw_l1[7:0]);
      chk("R1 level 2 wins", 32'(priv_level), 32'd2);
      pw_l2 = 32'hCAFE_F00D;
      put_word(32'h0BAD_0BAD);
      chk("R1 no match is user", 32'(priv_level), 32'd0);

      // R9 read data masking
      put_word(pw_l2);
      req_valid = 1'b1; req_table = 3'd1; rd_data_in = 8'h5C; #1;
      chk("R9 normal read passes", 32'(rd_data_out), 32'h5C);
      req_pw_loc = 1'b1; #1;
      chk("R9 password location zero", 32'(rd_data_out), 32'h00);
      req_pw_loc = 1'b0; req_table = 3'd7; #1;
      chk("R9 denied read zero", 32'(rd_data_out), 32'h00);
      req_valid = 1'b0;

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule